// File: doc/BRIEF.md
# Mirrored-Core Barrel Shifter with Overflow and Zero Flags

This block is a purely combinational word shifter. It takes a data word, a shift count and a three-bit operation select. In the same path it returns the shifted or rotated word, an overflow indication and a zero-result indication. Six operations are available: logical and arithmetic shifts in both directions, and rotates in both directions.

All six operations share one right-rotating network of log2(W) stages. Left operations mirror the word on entry and again on exit. A mask with ones in the top `shamt` positions is built from the count. It inserts zero or sign fill after the rotation. The overflow and zero flags use the same mask and its mirror image applied to the input word, so they do not wait for the rotator to settle.

Top module: `mirror_shifter`

## Requirements
- R1: With `op` = 000 (right logical), `res` equals `din` shifted right by `shamt` and the vacated upper bits are 0.
- R2: With `op` = 001 (right arithmetic), `res` equals `din` shifted right by `shamt` and the vacated upper bits copy `din[W-1]`.
- R3: With `op` = 010 or 011 (right rotate), `res[i]` equals `din[(i+shamt) mod W]`.
- R4: With `op` = 100 (left logical), `res` equals `din` shifted left by `shamt` and the vacated lower bits are 0.
- R5: With `op` = 101 (left arithmetic), `res` is the same word as for left logical.
- R6: With `op` = 110 or 111 (left rotate), `res[i]` equals `din[(i-shamt) mod W]`.
- R7: With `shamt` = 0, `res` equals `din` for every `op`.
- R8: For left logical, `ovf` is 1 exactly when at least one of the top `shamt` bits of `din` is 1.
- R9: For left arithmetic, `ovf` is 1 exactly when at least one of the top `shamt`+1 bits of `din` differs from `din[W-1]`.
- R10: For right shifts and for rotates of either direction, `ovf` is 0.
- R11: For the four shift operations, `zf` is 1 exactly when `res` is all zeros.
- R12: For rotates, `zf` is 1 exactly when `din` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | W | Word to be shifted or rotated |
| shamt | input | log2(W) | Shift or rotate count |
| op | input | 3 | Bit 2 selects left, bit 1 selects rotate, bit 0 selects arithmetic when not rotating |
| res | output | W | Shifted or rotated word |
| ovf | output | 1 | Left shift lost significant information |
| zf | output | 1 | Result is all zeros |

## Verification
The hardest case to reach is the edge of left-arithmetic overflow. That happens when the only bit differing from the sign is at position W-1-shamt, exactly one place below the positions the count discards. Random words rarely land there. The stimulus therefore walks every count and places a single disagreeing bit just inside and just outside that window, with both sign values. It also puts a single set bit on each side of the mask edge, so the logical-shift zero flag and overflow flag are checked at their boundary for every count.

// File: rtl/mirror_shifter.sv
module mirror_shifter #(
  parameter int W = 32,
  localparam int SW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] shamt,
  input  logic [2:0]    op,
  output logic [W-1:0]  res,
  output logic          ovf,
  output logic          zf
);

  function automatic logic [W-1:0] mirror(input logic [W-1:0] v);
    logic [W-1:0] m;
    for (int i = 0; i < W; i++) m[i] = v[W-1-i];
    return m;
  endfunction

  logic          go_left, go_rot, go_arith;
  logic [W-1:0]  top_mask, low_mask, sla_mask, fill, keep, core_out;
  logic [W-1:0]  stage [SW+1];

  assign go_left  = op[2];
  assign go_rot   = op[1];
  assign go_arith = op[0] & ~op[1] & ~op[2];

  assign stage[0] = go_left ? mirror(din) : din;

  for (genvar k = 0; k < SW; k++) begin : g_rot
    localparam int P = 1 << k;
    assign stage[k+1] = shamt[k] ? {stage[k][P-1:0], stage[k][W-1:P]} : stage[k];
  end

  assign top_mask = ~({W{1'b1}} >> shamt);
  assign low_mask = mirror(top_mask);
  assign sla_mask = {1'b1, top_mask[W-1:1]};
  assign fill     = go_arith ? {W{din[W-1]}} : '0;

  assign core_out = go_rot ? stage[SW] : ((stage[SW] & ~top_mask) | (fill & top_mask));
  assign res      = go_left ? mirror(core_out) : core_out;

  assign keep = go_left ? ~top_mask : ~low_mask;
  assign zf   = go_rot ? ~|din : ~|(din & keep);

  always_comb begin
    case (op)
      3'b100:  ovf = |(din & top_mask);
      3'b101:  ovf = |((din ^ {W{din[W-1]}}) & sla_mask);
      default: ovf = 1'b0;
    endcase
  end

endmodule

module mirror_shifter_chk #(
  parameter int W = 32,
  localparam int SW = $clog2(W)
) (
  input logic [W-1:0]  din,
  input logic [SW-1:0] shamt,
  input logic [2:0]    op,
  input logic [W-1:0]  res,
  input logic          ovf,
  input logic          zf
);
  always_comb begin
    if (!$isunknown({din, shamt, op, res, ovf, zf})) begin
      assert_zero_flag_R11: assert (op[1] || (zf == (res == '0)))
        else $error("zf disagrees with result");
      assert_rot_zero_R12: assert (!op[1] || (zf == (din == '0)))
        else $error("rotate zf disagrees with input");
      assert_no_overflow_R10: assert (op[2] && !op[1] || !ovf)
        else $error("overflow on right shift or rotate");
      assert_identity_R7: assert (shamt != '0 || res == din)
        else $error("zero count changed word");
      assert_rot_bits_R3: assert (!op[1] || $countones(res) == $countones(din))
        else $error("rotate changed bit count");
      assert_sign_kept_R2: assert (op != 3'b001 || res[W-1] == din[W-1])
        else $error("arithmetic right lost sign");
      assert_lossless_R8: assert (op != 3'b100 || ovf || (res >> shamt) == din)
        else $error("left shift lost bits without overflow");
    end
  end
endmodule

bind mirror_shifter mirror_shifter_chk #(.W(W)) chk_i (.*);

// File: tb/mirror_shifter_tb_top.sv
module mirror_shifter_tb_top;
  localparam int W  = 32;
  localparam int SW = $clog2(W);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [W-1:0]  din;
  logic [SW-1:0] shamt;
  logic [2:0]    op;
  logic [W-1:0]  res;
  logic          ovf, zf;

  int n_chk = 0, n_bad = 0;

  mirror_shifter #(.W(W)) dut_i (.din(din), .shamt(shamt), .op(op), .res(res), .ovf(ovf), .zf(zf));

  function automatic string res_tag(input logic [2:0] o, input int s);
    if (s == 0) return "R7";
    case (o)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010, 3'b011: return "R3";
      3'b100: return "R4";
      3'b101: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s op=%b shamt=%0d din=%h actual=%h expected=%h", tag, op, shamt, din, act, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] d, input int s, input logic [2:0] o);
    logic [W-1:0] e;
    logic eo;
    @(posedge clk);
    din = d; shamt = SW'(s); op = o;
    e = '0; eo = 1'b0;
    for (int i = 0; i < W; i++) begin
      case (o)
        3'b000: e[i] = (i + s < W) ? d[i+s] : 1'b0;
        3'b001: e[i] = (i + s < W) ? d[i+s] : d[W-1];
        3'b010, 3'b011: e[i] = d[(i + s) % W];
        3'b100, 3'b101: e[i] = (i - s >= 0) ? d[i-s] : 1'b0;
        default: e[i] = d[(i - s + W) % W];
      endcase
      if (o == 3'b100 && i >= W - s && d[i]) eo = 1'b1;
      if (o == 3'b101 && i >= W - 1 - s && d[i] != d[W-1]) eo = 1'b1;
    end
    @(negedge clk);
    check(res_tag(o, s), res, e);
    if (o == 3'b100) check("R8", W'(ovf), W'(eo));
    else if (o == 3'b101) check("R9", W'(ovf), W'(eo));
    else check("R10", W'(ovf), W'(eo));
    if (o[1]) check("R12", W'(zf), W'(d == '0));
    else check("R11", W'(zf), W'(e == '0));
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [W-1:0] pats [8];
    din = '0; shamt = '0; op = '0;
    pats[0] = '0;
    pats[1] = '1;
    pats[2] = W'(1);
    pats[3] = W'(1) << (W - 1);
    pats[4] = {(W/2){2'b10}};
    pats[5] = {(W/2){2'b01}};
    pats[6] = W'(32'h0000_8001);
    pats[7] = ~W'(32'h0000_8001);
    for (int o = 0; o < 8; o++)
      apply('0, 0, 3'(o));
    for (int o = 0; o < 8; o++)
      for (int s = 0; s < W; s++) begin
        for (int p = 0; p < 8; p++) apply(pats[p], s, 3'(o));
        for (int r = 0; r < 4; r++) apply(W'($urandom), s, 3'(o));
      end
    for (int s = 0; s < W; s++) begin
      if (W - 1 - s < W - 1) begin
        apply(W'(1) << (W - 1 - s), s, 3'b101);
        apply(~(W'(1) << (W - 1 - s)), s, 3'b101);
      end
      if (W - 2 - s >= 0) begin
        apply(W'(1) << (W - 2 - s), s, 3'b101);
        apply(~(W'(1) << (W - 2 - s)), s, 3'b101);
      end
      if (s > 0) begin
        apply(W'(1) << (W - s), s, 3'b100);
        apply(W'(1) << (s - 1), s, 3'b000);
        apply(W'(1) << s, s, 3'b000);
      end
      apply(W'(1) << (W - 1 - s), s, 3'b100);
    end
    summary();
  end
endmodule